// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is the counting alarm of a real-time clock. Software loads the number of seconds left until the alarm into a count register, arms the countdown and chooses whether an expiry should raise the interrupt line, the wakeup line, or both. A one-cycle tick pulse, produced elsewhere once per second in the bus clock domain, moves the count down by one while the countdown is armed. When the count steps from one to zero, a pending flag is set. That flag then holds until software clears it with a write-one-to-clear access.

The count can be read at any time and always returns the live remaining value. If zero is written to the count, any countdown in progress is dropped without an expiry. This lets software cancel an alarm safely before it loads a new one. Both outputs are the pending flag gated by their own enable bit. The interrupt enable and the wakeup enable are independent of each other.

Top module: `alarm_countdown`

## Requirements
- R1: After reset, every register reads zero, the count is zero, and both `irq_o` and `wake_o` are low.
- R2: A write to offset 0x20 loads the full 32-bit write data into the count. A read of offset 0x20 returns the live count.
- R3: When a tick arrives while the arm bit is set and the count is nonzero, the count drops by exactly one at that clock edge. This holds from any start value, including 0xFFFFFFFF.
- R4: A tick has no effect on the count while the arm bit (offset 0x28, bit 0) is clear.
- R5: The tick that takes the count from 1 to 0 while armed sets the pending flag at the same edge. The flag reads as bit 0 of offset 0x30. Nothing else sets it.
- R6: Once the count is zero, further ticks leave it at zero with no wrap, and they do not set the pending flag again.
- R7: Writing offset 0x30 with bit 0 set clears the pending flag. Writing it with bit 0 clear leaves the flag unchanged.
- R8: If an expiry and a clear of the pending flag happen in the same cycle, the flag ends up set.
- R9: `irq_o` is high exactly when the pending flag is set and the interrupt enable (offset 0x2C, bit 0) is set.
- R10: `wake_o` is high exactly when the pending flag is set and the wakeup enable (offset 0x50, bit 0) is set.
- R11: A count write at the same edge as a tick loads the written value and does not decrement. Writing zero cancels a running countdown without setting the pending flag.
- R12: The arm, interrupt-enable and wakeup-enable registers keep only bit 0 and read zero in all other bits. Any unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_addr_i | input | 8 | Byte offset of the register accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| irq_o | output | 1 | Interrupt request, level |
| wake_o | output | 1 | Wakeup request, level |

## Verification
The properties assume that `tick_i` is a single-cycle pulse sampled on `clk_i` and that a write strobe carries one offset per cycle. They also assume that the count moves only through a load or an armed tick. The stimulus applies every input change at the falling edge and holds it for exactly one rising edge. Ticks are issued only as isolated pulses or together with one bus write, which is the intended same-cycle collision. Reads are combinational on the offset, so the bench reads the count between edges without disturbing it.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

    // Register offsets decoded by the block (byte addresses)
    localparam logic [7:0] OFF_COUNT  = 8'h20;
    localparam logic [7:0] OFF_ARM    = 8'h28;
    localparam logic [7:0] OFF_IRQEN  = 8'h2C;
    localparam logic [7:0] OFF_STATUS = 8'h30;
    localparam logic [7:0] OFF_WAKEEN = 8'h50;

    typedef struct packed {
        logic arm;
        logic irq_en;
        logic wake_en;
    } ctl_t;

endpackage

// File: rtl/ctd_regs.sv
module ctd_regs
    import ctd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_arm_i,
    input  logic wr_irqen_i,
    input  logic wr_wakeen_i,
    input  logic wbit_i,
    output ctl_t ctl_o
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_arm_i)    ctl_d.arm     = wbit_i;
        if (wr_irqen_i)  ctl_d.irq_en  = wbit_i;
        if (wr_wakeen_i) ctl_d.wake_en = wbit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/ctd_counter.sv
module ctd_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             arm_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d     = st_q;
        step     = arm_i && tick_i && !load_i && (st_q.cnt != '0);
        expire_o = step && (st_q.cnt == ONE);
        if (load_i)    st_d.cnt = load_val_i;
        else if (step) st_d.cnt = st_q.cnt - ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/ctd_flag.sv
module ctd_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.pend = 1'b1;   // setting has priority over clearing
        else if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
    import ctd_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_i,
    output logic              irq_o,
    output logic              wake_o
);

    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFF_ARM);
    localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFF_IRQEN);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_WAKEEN = ADDR_W'(OFF_WAKEEN);

    logic             wr_count, wr_arm, wr_irqen, wr_status, wr_wakeen;
    ctl_t             ctl;
    logic             arm;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             pending;
    logic [DATA_W-1:0] cnt_ext;

    always_comb begin
        wr_count  = bus_wr_i && (bus_addr_i == A_COUNT);
        wr_arm    = bus_wr_i && (bus_addr_i == A_ARM);
        wr_irqen  = bus_wr_i && (bus_addr_i == A_IRQEN);
        wr_status = bus_wr_i && (bus_addr_i == A_STATUS);
        wr_wakeen = bus_wr_i && (bus_addr_i == A_WAKEEN);
    end

    ctd_regs u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_arm_i    (wr_arm),
        .wr_irqen_i  (wr_irqen),
        .wr_wakeen_i (wr_wakeen),
        .wbit_i      (bus_wdata_i[0]),
        .ctl_o       (ctl)
    );

    assign arm = ctl.arm;

    ctd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (wr_count),
        .load_val_i (bus_wdata_i[CNT_W-1:0]),
        .tick_i     (tick_i),
        .arm_i      (arm),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    ctd_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (expire),
        .clr_i  (wr_status && bus_wdata_i[0]),
        .pend_o (pending)
    );

    always_comb begin
        cnt_ext             = '0;
        cnt_ext[CNT_W-1:0]  = cnt;
        bus_rdata_o         = '0;
        case (bus_addr_i)
            A_COUNT:  bus_rdata_o    = cnt_ext;
            A_ARM:    bus_rdata_o[0] = ctl.arm;
            A_IRQEN:  bus_rdata_o[0] = ctl.irq_en;
            A_STATUS: bus_rdata_o[0] = pending;
            A_WAKEEN: bus_rdata_o[0] = ctl.wake_en;
            default:  bus_rdata_o    = '0;
        endcase
    end

    assign irq_o  = pending && ctl.irq_en;
    assign wake_o = pending && ctl.wake_en;

endmodule

// File: rtl/ctd_checker.sv
module ctd_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick,
    input logic              arm,
    input logic [CNT_W-1:0]  cnt,
    input logic              pending,
    input logic              irq,
    input logic              wake
);

    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(8'h20));

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && tick && !cnt_wr && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3

    AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !cnt_wr) |=> $stable(cnt)); // R4

    AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && tick && !cnt_wr && cnt == CNT_W'(1)) |=> pending); // R8

    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(arm && tick && !cnt_wr && cnt == CNT_W'(1))); // R5

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !cnt_wr) |=> (cnt == '0)); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(bus_wdata[CNT_W-1:0]))); // R11

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending); // R9

    AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> pending); // R10

endmodule

bind alarm_countdown ctd_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_ctd_checker (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .tick      (tick_i),
    .arm       (arm),
    .cnt       (cnt),
    .pending   (pending),
    .irq       (irq_o),
    .wake      (wake_o)
);

// File: tb/tb_alarm_countdown.sv
`timescale 1ns/1ps
module tb_alarm_countdown;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic        irq, wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alarm_countdown dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_i      (tick),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    // Scoreboard item: kind 0 = read data, 1 = irq pin, 2 = wake pin
    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t sbq[$];

    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        #1;
        while (sbq.size() > 0) begin
            it = sbq.pop_front();
            case (it.kind)
                0:       act = rdata;
                1:       act = {31'b0, irq};
                default: act = {31'b0, wake};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] v, input string tag);
        @(negedge clk);
        wr = 1'b0; tick = 1'b0; addr = a;
        sbq.push_back('{tag, 0, v});
    endtask

    task automatic exp_pin(input int kind, input logic v, input string tag);
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        sbq.push_back('{tag, kind, {31'b0, v}});
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        exp_reg(8'h20, 32'h0, "R1 count");
        exp_reg(8'h28, 32'h0, "R1 arm");
        exp_reg(8'h2C, 32'h0, "R1 irq enable");
        exp_reg(8'h30, 32'h0, "R1 status");
        exp_reg(8'h50, 32'h0, "R1 wake enable");
        exp_pin(1, 1'b0, "R1 irq");
        exp_pin(2, 1'b0, "R1 wake");

        // R2 load and read back
        cyc(1'b1, 8'h20, 32'd5, 1'b0);
        exp_reg(8'h20, 32'd5, "R2 load");
        cyc(1'b1, 8'h2C, 32'h1, 1'b0);

        // R4 tick while disarmed
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'd5, "R4 disarmed tick");

        cyc(1'b1, 8'h28, 32'h1, 1'b0);
        exp_reg(8'h28, 32'h1, "R12 arm readback");

        // R3 countdown
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'd4, "R3 first step");
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'd1, "R3 steps to one");
        exp_reg(8'h30, 32'h0, "R5 no early pending");

        // R5 expiry
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'd0, "R5 count zero");
        exp_reg(8'h30, 32'h1, "R5 pending set");
        exp_pin(1, 1'b1, "R9 irq with enable");
        exp_pin(2, 1'b0, "R10 wake without enable");

        // R6 no wrap
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'd0, "R6 stays zero");

        // R7 write-one-to-clear
        cyc(1'b1, 8'h30, 32'h0, 1'b0);
        exp_reg(8'h30, 32'h1, "R7 zero write keeps flag");
        cyc(1'b1, 8'h30, 32'h1, 1'b0);
        exp_reg(8'h30, 32'h0, "R7 one write clears");
        exp_pin(1, 1'b0, "R9 irq follows clear");
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h30, 32'h0, "R6 no second expiry");

        // R8 set wins over clear in the same cycle
        cyc(1'b1, 8'h2C, 32'h0, 1'b0);
        cyc(1'b1, 8'h50, 32'h1, 1'b0);
        cyc(1'b1, 8'h20, 32'd1, 1'b0);
        cyc(1'b1, 8'h30, 32'h1, 1'b1);
        exp_reg(8'h30, 32'h1, "R8 set beats clear");
        exp_pin(1, 1'b0, "R9 irq masked");
        exp_pin(2, 1'b1, "R10 wake enabled");
        cyc(1'b1, 8'h30, 32'h1, 1'b0);
        exp_pin(2, 1'b0, "R10 wake after clear");

        // R11 load beats tick, zero cancels
        cyc(1'b1, 8'h20, 32'd3, 1'b0);
        cyc(1'b1, 8'h20, 32'd7, 1'b1);
        exp_reg(8'h20, 32'd7, "R11 load beats tick");
        cyc(1'b1, 8'h20, 32'd0, 1'b0);
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'd0, "R11 cancel count");
        exp_reg(8'h30, 32'h0, "R11 cancel no pending");

        // R3 full-width start
        cyc(1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'hFFFF_FFFE, "R3 wide step");

        // R4 disarm freezes count
        cyc(1'b1, 8'h28, 32'h0, 1'b0);
        cyc(1'b0, 8'h00, 32'h0, 1'b1);
        exp_reg(8'h20, 32'hFFFF_FFFE, "R4 frozen");

        // R12 unmapped and masked bits
        exp_reg(8'h24, 32'h0, "R12 unmapped");
        cyc(1'b1, 8'h28, 32'hFFFF_FFFF, 1'b0);
        exp_reg(8'h28, 32'h1, "R12 arm bit only");
        cyc(1'b1, 8'h50, 32'hFFFF_FFFE, 1'b0);
        exp_reg(8'h50, 32'h0, "R12 wake bit only");

        @(negedge clk);
        #2;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule